// File: doc/BRIEF.md
# Segmented DAC Code Decoder

This block is the registered digital front end of a 12-bit segmented current-steering converter. Each input word passes through two register stages. The first stage holds the raw word. The second stage holds the decoded switch controls, so every control reaches the current cells on the same clock edge and none of them skews against the others.

The low eight bits of the word are forwarded unchanged as binary-weighted ladder controls. The high four bits become a 15-line thermometer: an upper nibble of value k turns on the k lowest segments. A second set of controls drives the inverted output path with the value 4095 minus the code. The two paths together therefore always add up to full scale minus one LSB.

A registered weight output rebuilds the code from the decoded controls. It is there so that verification can see the result directly.

Top module: `segdac_front`

## Requirements
- R1: A synchronous active-high reset clears both register stages. After a reset edge, `lad_p` and `seg_p` are all 0, `lad_n` and `seg_n` are all 1, and `wt_p` is 0.
- R2: Latency from input to output is fixed at two rising edges. The word present at edge E appears on all outputs after edge E+1, and the outputs do not change between edges.
- R3: `lad_p[i]` equals code bit i for i = 0..7.
- R4: `seg_p` bit j is 1 exactly when the upper nibble (code bits 11..8) is greater than j, for j = 0..14. The active segments are therefore contiguous from bit 0.
- R5: `lad_n` is the bitwise inverse of code bits 7..0. `seg_n` is the thermometer of 15 minus the upper nibble, which enables its lowest (15 - k) lines.
- R6: `wt_p` equals 256 times the number of set `seg_p` bits plus `lad_p`, which is the registered code. The complementary weight (256 times the number of set `seg_n` bits plus `lad_n`) equals 4095 minus `wt_p`.
- R7: The three endpoint codes decode as follows. Code 0xFFF gives all 15 segments and all ladder bits on the main side and nothing on the complementary side. Code 0x800 gives 8 segments and 0 ladder bits on the main side, and 7 segments with all ladder bits on the complementary side. Code 0x000 gives the reverse of 0xFFF.
- R8: Inside any block of 256 consecutive codes, `seg_p` and `seg_n` stay fixed. They change only when the code crosses a multiple of 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| code_in | input | 12 | Input code, bit 11 most significant |
| lad_p | output | 8 | Binary ladder controls, main path |
| seg_p | output | 15 | Thermometer segment enables, main path |
| lad_n | output | 8 | Binary ladder controls, complementary path |
| seg_n | output | 15 | Thermometer segment enables, complementary path |
| wt_p | output | 12 | Registered weight rebuilt from the main controls |

## Verification
The bench steps through all 4096 codes. At every 256-code boundary, a thermometer with an off-by-one compare would light one segment too many or too few, and a decoder built on the wrong nibble would move its segments inside a block. The complementary path is checked against 4095 minus the code, so a design that merely inverted `seg_p` would fail: its enables would sit at the top of the bank rather than at the bottom. A latency check swaps the code between two edges, which exposes a design that skips or adds a pipeline stage.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
  localparam int DEF_LAD_W = 8;
  localparam int DEF_NIB_W = 4;

  function automatic int unsigned count_set(input logic [63:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 64; i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/segdac_capture.sv
module segdac_capture #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/segdac_therm.sv
module segdac_therm #(
  parameter int NIB_W = 4,
  localparam int NSEG = (1 << NIB_W) - 1
) (
  input  logic [NIB_W-1:0] level,
  output logic [NSEG-1:0]  en
);
  for (genvar j = 0; j < NSEG; j++) begin : g_seg
    assign en[j] = (32'(level) > j);
  end
endmodule

// File: rtl/segdac_drive_reg.sv
module segdac_drive_reg #(
  parameter int LAD_W = 8,
  parameter int NSEG  = 15,
  parameter int CW    = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LAD_W-1:0] lad_p_d,
  input  logic [NSEG-1:0]  seg_p_d,
  input  logic [LAD_W-1:0] lad_n_d,
  input  logic [NSEG-1:0]  seg_n_d,
  input  logic [CW-1:0]    wt_d,
  output logic [LAD_W-1:0] lad_p,
  output logic [NSEG-1:0]  seg_p,
  output logic [LAD_W-1:0] lad_n,
  output logic [NSEG-1:0]  seg_n,
  output logic [CW-1:0]    wt_p
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lad_p <= '0;
      seg_p <= '0;
      lad_n <= '1;
      seg_n <= '1;
      wt_p  <= '0;
    end else begin
      lad_p <= lad_p_d;
      seg_p <= seg_p_d;
      lad_n <= lad_n_d;
      seg_n <= seg_n_d;
      wt_p  <= wt_d;
    end
  end
endmodule

// File: rtl/segdac_front.sv
module segdac_front #(
  parameter int LAD_W = segdac_pkg::DEF_LAD_W,
  parameter int NIB_W = segdac_pkg::DEF_NIB_W,
  localparam int CW   = LAD_W + NIB_W,
  localparam int NSEG = (1 << NIB_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    code_in,
  output logic [LAD_W-1:0] lad_p,
  output logic [NSEG-1:0]  seg_p,
  output logic [LAD_W-1:0] lad_n,
  output logic [NSEG-1:0]  seg_n,
  output logic [CW-1:0]    wt_p
);
  logic [CW-1:0]    held;
  logic [NIB_W-1:0] nib_p, nib_n;
  logic [NSEG-1:0]  seg_p_d, seg_n_d;
  logic [LAD_W-1:0] lad_p_d, lad_n_d;
  logic [NIB_W-1:0] cnt_p;
  logic [CW-1:0]    wt_d;

  segdac_capture #(.W(CW)) u_capture (
    .clk(clk), .rst(rst), .d(code_in), .q(held)
  );

  assign nib_p   = held[CW-1:LAD_W];
  assign nib_n   = ~nib_p;
  assign lad_p_d = held[LAD_W-1:0];
  assign lad_n_d = ~held[LAD_W-1:0];

  segdac_therm #(.NIB_W(NIB_W)) u_therm_p (.level(nib_p), .en(seg_p_d));
  segdac_therm #(.NIB_W(NIB_W)) u_therm_n (.level(nib_n), .en(seg_n_d));

  always_comb begin
    cnt_p = NIB_W'(segdac_pkg::count_set(64'(seg_p_d)));
    wt_d  = {cnt_p, lad_p_d};
  end

  segdac_drive_reg #(.LAD_W(LAD_W), .NSEG(NSEG), .CW(CW)) u_drive (
    .clk(clk), .rst(rst),
    .lad_p_d(lad_p_d), .seg_p_d(seg_p_d),
    .lad_n_d(lad_n_d), .seg_n_d(seg_n_d), .wt_d(wt_d),
    .lad_p(lad_p), .seg_p(seg_p), .lad_n(lad_n), .seg_n(seg_n), .wt_p(wt_p)
  );
endmodule

// File: rtl/segdac_front_chk.sv
module segdac_front_chk #(
  parameter int LAD_W = 8,
  parameter int NIB_W = 4,
  localparam int CW   = LAD_W + NIB_W,
  localparam int NSEG = (1 << NIB_W) - 1
) (
  input logic             clk,
  input logic             rst,
  input logic [CW-1:0]    code_in,
  input logic [LAD_W-1:0] lad_p,
  input logic [NSEG-1:0]  seg_p,
  input logic [LAD_W-1:0] lad_n,
  input logic [NSEG-1:0]  seg_n,
  input logic [CW-1:0]    wt_p
);
  logic [1:0] live;
  always_ff @(posedge clk) begin
    if (rst)            live <= '0;
    else if (live != 2) live <= live + 2'd1;
  end

  // R1
  rst_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (seg_p == '0 && lad_p == '0 && seg_n == '1 && lad_n == '1 && wt_p == '0));

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (live == 2) |-> (wt_p == $past(code_in, 2)));

  // R3
  ladder_chk: assert property (@(posedge clk) disable iff (rst)
    (live == 2) |-> (lad_p == $past(code_in[LAD_W-1:0], 2)));

  // R4
  contig_chk: assert property (@(posedge clk) disable iff (rst)
    ((seg_p & (seg_p + 1'b1)) == '0) && ((seg_n & (seg_n + 1'b1)) == '0));

  // R5
  comp_sum_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(seg_p) + $countones(seg_n) == NSEG) && ((lad_p ^ lad_n) == '1));

  // R8
  block_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (live == 2 && $past(code_in[CW-1:LAD_W], 2) == $past(code_in[CW-1:LAD_W], 3)
     && $past(live) == 2) |-> $stable(seg_p));
endmodule

bind segdac_front segdac_front_chk #(.LAD_W(LAD_W), .NIB_W(NIB_W)) u_chk (
  .clk(clk), .rst(rst), .code_in(code_in), .lad_p(lad_p), .seg_p(seg_p),
  .lad_n(lad_n), .seg_n(seg_n), .wt_p(wt_p)
);

// File: tb/segdac_front_bench.sv
`timescale 1ns/1ps
module segdac_front_bench;
  logic        clk = 0;
  logic        rst = 1;
  logic [11:0] code_in = '0;
  logic [7:0]  lad_p, lad_n;
  logic [14:0] seg_p, seg_n;
  logic [11:0] wt_p;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  segdac_front u_segdac_front (
    .clk(clk), .rst(rst), .code_in(code_in), .lad_p(lad_p), .seg_p(seg_p),
    .lad_n(lad_n), .seg_n(seg_n), .wt_p(wt_p)
  );

  function automatic logic [14:0] therm(input int k);
    logic [14:0] r;
    for (int j = 0; j < 15; j++) r[j] = (k > j);
    return r;
  endfunction

  function automatic int ones(input logic [14:0] v);
    int n = 0;
    for (int j = 0; j < 15; j++) n += int'(v[j]);
    return n;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_code(input int c, input bit all);
    int k = c >> 8;
    check("R3 ladder", lad_p, c & 8'hFF);
    check("R4 segments", seg_p, therm(k));
    check("R5 comp ladder", lad_n, ~c & 8'hFF);
    check("R5 comp segments", seg_n, therm(15 - k));
    if (all) begin
      check("R6 weight", wt_p, c);
      check("R6 comp weight", ones(seg_n) * 256 + lad_n, 4095 - c);
    end
  endtask

  task automatic apply(input int c);
    @(negedge clk) code_in = 12'(c);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1;
    @(negedge clk) code_in = 12'hABC;
    @(negedge clk);
    check("R1 lad_p", lad_p, 0);
    check("R1 seg_p", seg_p, 0);
    check("R1 lad_n", lad_n, 8'hFF);
    check("R1 seg_n", seg_n, 15'h7FFF);
    check("R1 wt_p", wt_p, 0);
    rst = 0;
  endtask

  task automatic t_endpoints();
    apply(12'hFFF); check_code(12'hFFF, 1);
    check("R7 full main segs", ones(seg_p), 15);
    check("R7 full comp segs", ones(seg_n), 0);
    apply(12'h800); check_code(12'h800, 1);
    check("R7 half main", ones(seg_p) * 256 + lad_p, 2048);
    check("R7 half comp", ones(seg_n) * 256 + lad_n, 2047);
    apply(12'h000); check_code(0, 1);
    check("R7 zero comp segs", ones(seg_n), 15);
  endtask

  task automatic t_latency();
    apply(12'h123);
    @(negedge clk) code_in = 12'h9A5;
    @(negedge clk);
    check("R2 after one edge", wt_p, 12'h123);
    @(negedge clk);
    check("R2 after two edges", wt_p, 12'h9A5);
    #2 check("R2 stable between edges", wt_p, 12'h9A5);
  endtask

  task automatic t_sweep();
    logic [14:0] prev_p, prev_n;
    code_in = 12'h000;
    @(negedge clk); @(negedge clk);
    prev_p = seg_p; prev_n = seg_n;
    for (int c = 1; c < 4096; c++) begin
      code_in = 12'(c);
      @(negedge clk);
      @(negedge clk);
      check_code(c, 1);
      if ((c & 8'hFF) != 0) begin
        check("R8 main held in block", seg_p, prev_p);
        check("R8 comp held in block", seg_n, prev_n);
      end else begin
        check("R8 main moves at boundary", int'(seg_p != prev_p), 1);
      end
      prev_p = seg_p; prev_n = seg_n;
    end
  endtask

  initial begin
    t_reset();
    t_latency();
    t_endpoints();
    t_sweep();
    t_reset();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule